// File: doc/BRIEF.md
# HDLC Receive/Transmit Pool Event Generator

This block sits between the FIFOs of one HDLC channel and a host processor and turns FIFO activity into host events. Data moves between the FIFOs and the host in pools of 32 bytes. On the receive side the block counts bytes as the deframer writes them into the receive FIFO. It raises a pool-full event each time a full pool of an unfinished frame is waiting. It raises a message-end event when the frame closes, and it keeps a 12-bit running length of the current frame, which the host reads as a low and a high byte. On the transmit side it raises a pool-ready event each time the transmitter has drained a full pool, so the host knows it may write the next one.

The host chooses between interrupt mode and DMA mode with `dma_mode`. In DMA mode the pool-full event is never raised. The message-end event waits until the DMA engine reports, on `dma_done`, that the frame has been moved correctly. When the deframer flags a frame end as an extended frame handled automatically, the block raises an extended-frame event in place of message-end. Events collect in a status register that clears when the host reads it. The single `irq` output is high when any status bit whose mask bit is 0 is set.

The receive controller has three states. `RX_IDLE` means no frame is open. `RX_FILL` means a frame is being received. `RX_WAIT_DMA` means the frame has ended in DMA mode and the block is waiting for the transfer to finish. The transitions are: start (`RX_IDLE` to `RX_FILL` on the first byte), close (`RX_IDLE`/`RX_FILL` back to `RX_IDLE` on a frame end in interrupt mode or on an extended frame), hand-off (`RX_IDLE`/`RX_FILL` to `RX_WAIT_DMA` on a normal frame end in DMA mode) and release (`RX_WAIT_DMA` to `RX_IDLE` on `dma_done`). A one-byte frame takes the first of the two close paths or the hand-off path in the same cycle as its start. The transmit controller has two states. `TX_BOOT` lasts for the first cycle after reset and moves on (boot-done) to `TX_RUN`, where it stays.

Top module: `hdlc_pool_irq`

## Requirements
- R1: While reset is active, the status register reads 0x00 and `irq` is low. Status bit 0 is message-end, bit 1 is receive-pool-full, bit 2 is transmit-pool-ready and bit 3 is extended-frame. Bits 7..4 always read 0.
- R2: In interrupt mode, bit 1 is set in the cycle after the 32nd, 64th, … byte of a frame is written (`rx_wr`), unless `rx_eof` is high in that same cycle.
- R3: In DMA mode, bit 1 is never set.
- R4: In interrupt mode, a normal frame end (`rx_eof` high, `rx_auto_ext` low) sets bit 0 in the next cycle.
- R5: In DMA mode, a normal frame end does not set bit 0. Bit 0 is set in the cycle after the `dma_done` pulse that follows the frame end.
- R6: A frame end with `rx_auto_ext` high sets bit 3 and never sets bit 0, in either mode.
- R7: The first byte of a new frame restarts the byte count at 1. A byte written in the same cycle as `rx_eof` is counted. `rbc_lo` carries count bits 7..0 and `rbc_hi` carries count bits 11..8 with zeros above them. The count holds after the frame ends until the next frame's first byte.
- R8: The byte count saturates at 4095 (`rbc_hi`=0x0F, `rbc_lo`=0xFF).
- R9: Bit 2 is set once in the first cycle after reset is released, and then once after every 32nd `tx_rd` pulse.
- R10: A `sta_rd` pulse clears all status bits in the next cycle. An event raised in the same cycle as the read stays set.
- R11: `irq` is high exactly when some status bit is set and its `irq_mask` bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dma_mode | input | 1 | 1 = DMA mode, 0 = interrupt mode |
| rx_wr | input | 1 | One byte written into the receive FIFO |
| rx_eof | input | 1 | Frame end seen by the deframer |
| rx_auto_ext | input | 1 | Qualifies `rx_eof`: the frame is an extended frame handled automatically |
| dma_done | input | 1 | The DMA transfer of the ended frame completed correctly |
| tx_rd | input | 1 | One byte taken from the transmit FIFO by the transmitter |
| sta_rd | input | 1 | Host read of the status register (clear on read) |
| irq_mask | input | 8 | Per-bit mask, 1 = suppress that bit on `irq` |
| status | output | 8 | Event status register |
| irq | output | 1 | Interrupt request |
| rbc_lo | output | 8 | Byte count, low byte |
| rbc_hi | output | 8 | Byte count, high byte |

## Verification
The embedded assertions check, on every cycle, the properties that can be stated locally. Upper status bits stay zero. Pool-full never rises in DMA mode. Extended-frame and message-end are never raised together. A read keeps exactly the events raised in its own cycle. A saturated count stays saturated. Consecutive transmit-ready events are never back to back. Only the directed scenarios show the exact byte on which pool-full fires, including the frame that ends on its 32nd byte. They also show the delay of message-end until `dma_done`, the reset-time transmit-ready event, the count restart on a new frame, and the mask's effect on `irq`.

// File: rtl/hpi_pkg.sv
package hpi_pkg;

    // Status bit positions (host-visible)
    localparam int BIT_MEND  = 0;
    localparam int BIT_PFULL = 1;
    localparam int BIT_TXRDY = 2;
    localparam int BIT_EXT   = 3;
    localparam int NUM_EVT   = 4;

    typedef enum logic [1:0] {
        RX_IDLE     = 2'd0,
        RX_FILL     = 2'd1,
        RX_WAIT_DMA = 2'd2
    } rx_state_t;

    typedef enum logic {
        TX_BOOT = 1'b0,
        TX_RUN  = 1'b1
    } tx_state_t;

endpackage

// File: rtl/hpi_rx_ctrl.sv
module hpi_rx_ctrl
    import hpi_pkg::*;
#(
    parameter int POOL_BYTES = 32,
    parameter int CNT_W      = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dma_mode,
    input  logic             rx_wr,
    input  logic             rx_eof,
    input  logic             rx_auto_ext,
    input  logic             dma_done,
    output logic             set_mend,
    output logic             set_pfull,
    output logic             set_ext,
    output logic [CNT_W-1:0] byte_cnt
);
    localparam int               PW        = $clog2(POOL_BYTES);
    localparam logic [PW-1:0]    POOL_LAST = PW'(POOL_BYTES - 1);
    localparam logic [CNT_W-1:0] CNT_MAX   = '1;

    rx_state_t        state_q, state_d;
    logic [PW-1:0]    pool_q, pool_d, base_pool;
    logic [CNT_W-1:0] cnt_q, cnt_d, base_cnt;
    logic             accept_wr, end_seen, pool_hit;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RX_IDLE;
            pool_q  <= '0;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            pool_q  <= pool_d;
            cnt_q   <= cnt_d;
        end
    end

    // Frame bookkeeping: a byte in RX_IDLE opens a new frame from zero
    always_comb begin
        base_cnt  = (state_q == RX_IDLE) ? '0 : cnt_q;
        base_pool = (state_q == RX_IDLE) ? '0 : pool_q;
        accept_wr = rx_wr && (state_q != RX_WAIT_DMA);
        end_seen  = rx_eof && (state_q != RX_WAIT_DMA) &&
                    ((state_q == RX_FILL) || accept_wr);
        pool_hit  = accept_wr && (base_pool == POOL_LAST);
        cnt_d     = cnt_q;
        pool_d    = pool_q;
        if (accept_wr) begin
            cnt_d  = (base_cnt == CNT_MAX) ? CNT_MAX : base_cnt + 1'b1;
            pool_d = base_pool + 1'b1;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_IDLE, RX_FILL: begin
                if (end_seen) begin
                    if (!rx_auto_ext && dma_mode) state_d = RX_WAIT_DMA;
                    else                          state_d = RX_IDLE;
                end else if (accept_wr) begin
                    state_d = RX_FILL;
                end
            end
            RX_WAIT_DMA: if (dma_done) state_d = RX_IDLE;
            default:     state_d = RX_IDLE;
        endcase
    end

    // Event outputs
    always_comb begin
        set_pfull = 1'b0;
        set_mend  = 1'b0;
        set_ext   = 1'b0;
        unique case (state_q)
            RX_IDLE, RX_FILL: begin
                set_pfull = pool_hit && !end_seen && !dma_mode;
                set_ext   = end_seen && rx_auto_ext;
                set_mend  = end_seen && !rx_auto_ext && !dma_mode;
            end
            RX_WAIT_DMA: set_mend = dma_done;
            default: ;
        endcase
    end

    assign byte_cnt = cnt_q;

    AST_CNT_HOLD_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_MAX) && (state_q != RX_IDLE) |=> (cnt_q == CNT_MAX)); // R8
    AST_NEW_FRAME_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RX_IDLE) && rx_wr |=> (cnt_q == CNT_W'(1))); // R7

endmodule

// File: rtl/hpi_tx_ctrl.sv
module hpi_tx_ctrl
    import hpi_pkg::*;
#(
    parameter int POOL_BYTES = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_rd,
    output logic set_txrdy
);
    localparam int            PW        = $clog2(POOL_BYTES);
    localparam logic [PW-1:0] POOL_LAST = PW'(POOL_BYTES - 1);

    tx_state_t     state_q;
    logic [PW-1:0] drain_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TX_BOOT;
            drain_q <= '0;
        end else begin
            state_q <= TX_RUN;
            if (tx_rd) drain_q <= drain_q + 1'b1;
        end
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            TX_BOOT: set_txrdy = 1'b1;
            TX_RUN:  set_txrdy = tx_rd && (drain_q == POOL_LAST);
            default: set_txrdy = 1'b0;
        endcase
    end

    AST_TXRDY_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        set_txrdy |=> !set_txrdy); // R9

endmodule

// File: rtl/hpi_status.sv
module hpi_status
    import hpi_pkg::*;
#(
    parameter int STW = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           rd_clr,
    input  logic           dma_mode,
    input  logic [STW-1:0] set_vec,
    input  logic [STW-1:0] mask,
    output logic [STW-1:0] status,
    output logic           irq
);
    logic [STW-1:0] status_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= (rd_clr ? '0 : status_q) | set_vec;
    end

    assign status = status_q;
    assign irq    = |(status_q & ~mask);

    always @(posedge clk) begin
        if (!rst_n) begin
            AST_RST_ZERO: assert (status_q == '0); // R1
        end
    end

    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        status_q[STW-1:NUM_EVT] == '0); // R1
    AST_PFULL_INT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_q[BIT_PFULL]) |-> !$past(dma_mode)); // R3
    AST_EXT_NOT_MEND: assert property (@(posedge clk) disable iff (!rst_n)
        set_vec[BIT_EXT] |-> !set_vec[BIT_MEND]); // R6
    AST_READ_KEEPS_NEW: assert property (@(posedge clk) disable iff (!rst_n)
        rd_clr |=> (status_q == $past(set_vec))); // R10

endmodule

// File: rtl/hdlc_pool_irq.sv
module hdlc_pool_irq
    import hpi_pkg::*;
#(
    parameter int POOL_BYTES = 32,
    parameter int CNT_W      = 12,
    parameter int STW        = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       dma_mode,
    input  logic       rx_wr,
    input  logic       rx_eof,
    input  logic       rx_auto_ext,
    input  logic       dma_done,
    input  logic       tx_rd,
    input  logic       sta_rd,
    input  logic [7:0] irq_mask,
    output logic [7:0] status,
    output logic       irq,
    output logic [7:0] rbc_lo,
    output logic [7:0] rbc_hi
);
    logic             set_mend, set_pfull, set_ext, set_txrdy;
    logic [CNT_W-1:0] byte_cnt;
    logic [STW-1:0]   set_vec;
    logic [15:0]      cnt_wide;

    hpi_rx_ctrl #(.POOL_BYTES(POOL_BYTES), .CNT_W(CNT_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .dma_mode(dma_mode),
        .rx_wr(rx_wr), .rx_eof(rx_eof), .rx_auto_ext(rx_auto_ext),
        .dma_done(dma_done),
        .set_mend(set_mend), .set_pfull(set_pfull), .set_ext(set_ext),
        .byte_cnt(byte_cnt)
    );

    hpi_tx_ctrl #(.POOL_BYTES(POOL_BYTES)) u_tx (
        .clk(clk), .rst_n(rst_n), .tx_rd(tx_rd), .set_txrdy(set_txrdy)
    );

    always_comb begin
        set_vec            = '0;
        set_vec[BIT_MEND]  = set_mend;
        set_vec[BIT_PFULL] = set_pfull;
        set_vec[BIT_TXRDY] = set_txrdy;
        set_vec[BIT_EXT]   = set_ext;
    end

    hpi_status #(.STW(STW)) u_sta (
        .clk(clk), .rst_n(rst_n), .rd_clr(sta_rd), .dma_mode(dma_mode),
        .set_vec(set_vec), .mask(irq_mask), .status(status), .irq(irq)
    );

    assign cnt_wide = 16'(byte_cnt);
    assign rbc_lo   = cnt_wide[7:0];
    assign rbc_hi   = cnt_wide[15:8];

endmodule

// File: tb/sim_hdlc_pool_irq.sv
module sim_hdlc_pool_irq;
    timeunit 1ns;
    timeprecision 1ps;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dma_mode = 1'b0, rx_wr = 1'b0, rx_eof = 1'b0, rx_auto_ext = 1'b0;
    logic       dma_done = 1'b0, tx_rd = 1'b0, sta_rd = 1'b0;
    logic [7:0] irq_mask = 8'h00;
    logic [7:0] status, rbc_lo, rbc_hi;
    logic       irq;
    int         n_chk = 0, n_fail = 0;

    always #10ns clk = ~clk;

    hdlc_pool_irq u0 (
        .clk(clk), .rst_n(rst_n), .dma_mode(dma_mode), .rx_wr(rx_wr),
        .rx_eof(rx_eof), .rx_auto_ext(rx_auto_ext), .dma_done(dma_done),
        .tx_rd(tx_rd), .sta_rd(sta_rd), .irq_mask(irq_mask),
        .status(status), .irq(irq), .rbc_lo(rbc_lo), .rbc_hi(rbc_hi)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr_bytes(input int n, input bit eof_last, input bit ext);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rx_wr       = 1'b1;
            rx_eof      = eof_last && (i == n - 1);
            rx_auto_ext = ext && (i == n - 1);
        end
        @(negedge clk);
        rx_wr = 1'b0; rx_eof = 1'b0; rx_auto_ext = 1'b0;
    endtask

    task automatic pulse_eof();
        @(negedge clk); rx_eof = 1'b1;
        @(negedge clk); rx_eof = 1'b0;
    endtask

    task automatic clr();
        @(negedge clk); sta_rd = 1'b1;
        @(negedge clk); sta_rd = 1'b0;
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk("R1 status in reset", status, 8'h00);
        chk("R1 irq in reset", irq, 0);
        chk("R7 count in reset", {rbc_hi, rbc_lo}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 boot tx ready", status, 8'h04);
        clr();
        chk("R10 read clears", status, 8'h00);
    endtask

    task automatic t_int_pool();
        dma_mode = 1'b0;
        wr_bytes(31, 0, 0);
        chk("R2 no pool full at 31", status, 8'h00);
        chk("R7 live count 31", rbc_lo, 31);
        wr_bytes(1, 0, 0);
        chk("R2 pool full at 32", status, 8'h02);
        clr();
        wr_bytes(8, 0, 0);
        chk("R2 no repeat before 64", status, 8'h00);
        wr_bytes(1, 1, 0);
        chk("R4 message end", status, 8'h01);
        chk("R7 count low 41", rbc_lo, 41);
        chk("R7 count high 0", rbc_hi, 0);
        clr();
    endtask

    task automatic t_end_on_32();
        wr_bytes(32, 1, 0);
        chk("R2 end on 32nd byte no pool full", status, 8'h01);
        chk("R7 count 32 incl eof byte", rbc_lo, 32);
        clr();
    endtask

    task automatic t_dma();
        dma_mode = 1'b1;
        wr_bytes(70, 0, 0);
        chk("R3 no pool full in DMA", status, 8'h00);
        wr_bytes(1, 1, 0);
        chk("R5 no message end at eof", status, 8'h00);
        repeat (4) @(negedge clk);
        chk("R5 still waiting for DMA", status, 8'h00);
        @(negedge clk); dma_done = 1'b1;
        @(negedge clk); dma_done = 1'b0;
        chk("R5 message end after dma_done", status, 8'h01);
        chk("R7 count 71", rbc_lo, 71);
        clr();
        dma_mode = 1'b0;
    endtask

    task automatic t_ext();
        wr_bytes(5, 1, 1);
        chk("R6 ext frame int mode", status, 8'h08);
        clr();
        dma_mode = 1'b1;
        wr_bytes(3, 1, 1);
        chk("R6 ext frame DMA mode", status, 8'h08);
        dma_mode = 1'b0;
        clr();
    endtask

    task automatic t_read_race();
        wr_bytes(3, 0, 0);
        @(negedge clk); rx_wr = 1'b1; rx_eof = 1'b1; sta_rd = 1'b1;
        @(negedge clk); rx_wr = 1'b0; rx_eof = 1'b0; sta_rd = 1'b0;
        chk("R10 event during read kept", status, 8'h01);
    endtask

    task automatic t_mask();
        irq_mask = 8'hFF; #1ns;
        chk("R11 all masked", irq, 0);
        irq_mask = 8'hFE; #1ns;
        chk("R11 bit0 unmasked", irq, 1);
        irq_mask = 8'hFD; #1ns;
        chk("R11 other bit unmasked", irq, 0);
        irq_mask = 8'h00;
        clr();
        chk("R11 irq low when clear", irq, 0);
    endtask

    task automatic t_tx();
        for (int i = 0; i < 31; i++) begin
            @(negedge clk); tx_rd = 1'b1;
        end
        @(negedge clk); tx_rd = 1'b0;
        chk("R9 not ready at 31", status, 8'h00);
        @(negedge clk); tx_rd = 1'b1;
        @(negedge clk); tx_rd = 1'b0;
        chk("R9 ready at 32", status, 8'h04);
        clr();
    endtask

    task automatic t_sat();
        wr_bytes(4100, 0, 0);
        chk("R8 sat low", rbc_lo, 8'hFF);
        chk("R8 sat high", rbc_hi, 8'h0F);
        pulse_eof();
        chk("R4 eof after long frame", status & 8'h01, 8'h01);
        chk("R8 sat held after end", {rbc_hi, rbc_lo}, 16'h0FFF);
        clr();
        wr_bytes(1, 0, 0);
        chk("R7 restart count low", rbc_lo, 1);
        chk("R7 restart count high", rbc_hi, 0);
    endtask

    initial begin
        t_reset();
        t_int_pool();
        t_end_on_32();
        t_dma();
        t_ext();
        t_read_race();
        t_mask();
        t_tx();
        t_sat();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL ALL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule